// File: doc/BRIEF.md
# Coprocessor-Space Instruction Router

This block sits behind the instruction pre-decoder and sorts each coprocessor-space instruction by the encoding region it falls in. Each of up to eight regions is set at reset to serve either the in-core custom datapath or an external coprocessor port. An instruction that neither can take raises a no-coprocessor fault. For every decoded instruction the block produces, one cycle later, a one-hot route, the register bank and class, the immediate split into an operation code and a constant, and the register-use flags that the pipeline's hazard logic has to honour.

The configuration comes from three 8-bit masks: custom-enable, coprocessor-present and coprocessor-enabled. They are captured on every clock edge while reset is held and are frozen once reset is released. A region marked both custom and usable by the coprocessor is a configuration error. The custom datapath wins such a conflict, and a status bit reports it.

Top module: `ext_op_router`

## Requirements
- R1: The three configuration masks are captured on clock edges while `rst_n` is low. Changes to them after reset is released have no effect on routing.
- R2: A valid instruction whose region bit is set in the captured custom mask, and whose kind is not 3, gets route `3'b001` (custom).
- R3: A valid instruction in a region without custom use, whose coprocessor-present and coprocessor-enabled bits are both set, gets route `3'b010` (coprocessor). This holds whatever its kind.
- R4: Any other valid instruction gets route `3'b100` (fault).
- R5: A region set both as custom and as present-and-enabled coprocessor routes to custom. `cfg_err` is high whenever any region has this conflict.
- R6: `out_valid` is high exactly one cycle after `in_valid` and low otherwise. `route` has exactly one bit set while `out_valid` is high and is zero otherwise. Both are zero in reset.
- R7: On a custom route, `out_use` carries the hazard flags with this bit layout:
  - bit 0: source 0 read, set when kind >= 1.
  - bit 1: source 1 read, set when kind == 2.
  - bit 2: destination read, equal to `in_acc`.
  - bit 3: destination write, always set.
  - bit 4: condition flags used, set when the bank is 0 (general-purpose).
  - bit 5: register pair, equal to `in_dual` and set only on bank 0.
  On any other route `out_use` is zero.
- R8: `out_opc` is `in_imm[2:0]`. `out_const` is `in_imm[w-1:3]`, zero-extended, where w is 13, 9 or 6 for kind 0, 1 or 2. Immediate bits at w and above have no effect.
- R9: Kind 3 is reserved. In a custom region it gets route `3'b100`.
- R10: `out_bank` and `out_kind` echo the instruction's bank (0 general-purpose, 1 floating-point/vector) and kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; configuration captured while low |
| cfg_custom | input | 8 | Region custom-datapath enable mask |
| cfg_cp_present | input | 8 | Region external coprocessor present mask |
| cfg_cp_enable | input | 8 | Region external coprocessor enabled mask |
| in_valid | input | 1 | Pre-decoded instruction valid |
| in_region | input | 3 | Encoding region number |
| in_bank | input | 1 | Register bank: 0 general-purpose, 1 floating-point/vector |
| in_kind | input | 2 | Class: 0, 1 or 2 source-operand forms; 3 reserved |
| in_acc | input | 1 | Accumulating form (destination also read) |
| in_dual | input | 1 | 64-bit register-pair form |
| in_imm | input | 13 | Raw immediate field |
| out_valid | output | 1 | Decoded result strobe, one cycle per instruction |
| route | output | 3 | One-hot: bit0 custom, bit1 coprocessor, bit2 fault |
| out_bank | output | 1 | Echoed bank |
| out_kind | output | 2 | Echoed class |
| out_opc | output | 3 | Operation code part of the immediate |
| out_const | output | 10 | Constant part of the immediate |
| out_use | output | 6 | Hazard flags as laid out in R7 |
| cfg_err | output | 1 | Some region is both custom and coprocessor-usable |

## Verification
The assertions check four things on every cycle: the strobe follows the input by one cycle, the route stays one-hot or idle, the hazard flags stay quiet off the custom route, and the custom side wins a conflicted region and faults on a reserved kind. The bench scenarios cover the rest: the whole region map under a mixed configuration, the immediate split for each class, and the flag layout for both banks. Only the bench can show that configuration changes after reset are ignored, because that needs stimulus over time.

// File: rtl/ext_op_pkg.sv
package ext_op_pkg;

  localparam logic [2:0] RT_CUS = 3'b001;
  localparam logic [2:0] RT_COP = 3'b010;
  localparam logic [2:0] RT_FLT = 3'b100;

  localparam logic [1:0] K_RSV = 2'd3;

  typedef struct packed {
    logic pair;
    logic flags;
    logic dst_wr;
    logic dst_rd;
    logic src1;
    logic src0;
  } use_t;

  // usable immediate width per class; wider classes carry fewer operands
  function automatic int unsigned imm_bits(input logic [1:0] kind, input int unsigned full_w);
    case (kind)
      2'd0:    imm_bits = full_w;
      2'd1:    imm_bits = full_w - 4;
      default: imm_bits = full_w - 7;
    endcase
  endfunction

  function automatic use_t hazard_use(input logic bank, input logic [1:0] kind,
                                      input logic acc, input logic dual);
    use_t u;
    u.src0   = (kind != 2'd0);
    u.src1   = (kind == 2'd2);
    u.dst_rd = acc;
    u.dst_wr = 1'b1;
    u.flags  = ~bank;
    u.pair   = dual & ~bank;
    return u;
  endfunction

endpackage

// File: rtl/ext_op_cfg.sv
module ext_op_cfg #(
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] cust_i,
  input  logic [NREG-1:0] pres_i,
  input  logic [NREG-1:0] ena_i,
  output logic [NREG-1:0] cust_q,
  output logic [NREG-1:0] cop_ok_q,
  output logic            conflict
);
  // capture while reset is held, freeze afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cust_q   <= cust_i;
      cop_ok_q <= pres_i & ena_i;
    end
  end

  assign conflict = |(cust_q & cop_ok_q);
endmodule

// File: rtl/ext_op_classify.sv
module ext_op_classify
  import ext_op_pkg::*;
#(
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic [NREG-1:0] cust_q,
  input  logic [NREG-1:0] cop_ok_q,
  input  logic [RW-1:0]   region,
  input  logic [1:0]      kind,
  output logic            sel_custom,
  output logic            sel_cop,
  output logic [2:0]      route
);
  assign sel_custom = cust_q[region];
  assign sel_cop    = cop_ok_q[region];

  always_comb begin
    if (sel_custom)   route = (kind == K_RSV) ? RT_FLT : RT_CUS;
    else if (sel_cop) route = RT_COP;
    else              route = RT_FLT;
  end
endmodule

// File: rtl/ext_op_fields.sv
module ext_op_fields
  import ext_op_pkg::*;
#(
  parameter int IMM_W = 13,
  parameter int OPC_W = 3,
  localparam int CONST_W = IMM_W - OPC_W
) (
  input  logic               bank,
  input  logic [1:0]         kind,
  input  logic               acc,
  input  logic               dual,
  input  logic [IMM_W-1:0]   imm,
  input  logic               to_custom,
  output logic [OPC_W-1:0]   opc,
  output logic [CONST_W-1:0] cnst,
  output use_t               use_f
);
  logic [IMM_W-1:0] mask;
  logic [IMM_W-1:0] masked;

  always_comb begin
    for (int i = 0; i < IMM_W; i++) begin
      mask[i] = (i < int'(imm_bits(kind, IMM_W)));
    end
  end

  assign masked = imm & mask;
  assign opc    = imm[OPC_W-1:0];
  assign cnst   = masked[IMM_W-1:OPC_W];
  assign use_f  = to_custom ? hazard_use(bank, kind, acc, dual) : '0;
endmodule

// File: rtl/ext_op_router.sv
module ext_op_router
  import ext_op_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int IMM_W = 13,
  parameter int OPC_W = 3,
  localparam int RW      = $clog2(NREG),
  localparam int CONST_W = IMM_W - OPC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREG-1:0]    cfg_custom,
  input  logic [NREG-1:0]    cfg_cp_present,
  input  logic [NREG-1:0]    cfg_cp_enable,
  input  logic               in_valid,
  input  logic [RW-1:0]      in_region,
  input  logic               in_bank,
  input  logic [1:0]         in_kind,
  input  logic               in_acc,
  input  logic               in_dual,
  input  logic [IMM_W-1:0]   in_imm,
  output logic               out_valid,
  output logic [2:0]         route,
  output logic               out_bank,
  output logic [1:0]         out_kind,
  output logic [OPC_W-1:0]   out_opc,
  output logic [CONST_W-1:0] out_const,
  output logic [5:0]         out_use,
  output logic               cfg_err
);
  logic [NREG-1:0]    cust_q, cop_ok_q;
  logic               sel_custom, sel_cop;
  logic [2:0]         route_d;
  logic [OPC_W-1:0]   opc_d;
  logic [CONST_W-1:0] cnst_d;
  use_t               use_d;

  ext_op_cfg #(.NREG(NREG)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .cust_i(cfg_custom), .pres_i(cfg_cp_present), .ena_i(cfg_cp_enable),
    .cust_q(cust_q), .cop_ok_q(cop_ok_q), .conflict(cfg_err)
  );

  ext_op_classify #(.NREG(NREG)) u_cls (
    .cust_q(cust_q), .cop_ok_q(cop_ok_q), .region(in_region), .kind(in_kind),
    .sel_custom(sel_custom), .sel_cop(sel_cop), .route(route_d)
  );

  ext_op_fields #(.IMM_W(IMM_W), .OPC_W(OPC_W)) u_fld (
    .bank(in_bank), .kind(in_kind), .acc(in_acc), .dual(in_dual), .imm(in_imm),
    .to_custom(route_d == RT_CUS), .opc(opc_d), .cnst(cnst_d), .use_f(use_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      route     <= '0;
      out_bank  <= 1'b0;
      out_kind  <= '0;
      out_opc   <= '0;
      out_const <= '0;
      out_use   <= '0;
    end else if (in_valid) begin
      out_valid <= 1'b1;
      route     <= route_d;
      out_bank  <= in_bank;
      out_kind  <= in_kind;
      out_opc   <= opc_d;
      out_const <= cnst_d;
      out_use   <= use_d;
    end else begin
      out_valid <= 1'b0;
      route     <= '0;
      out_use   <= '0;
    end
  end

  // R6: strobe follows the input by one cycle
  a_r6_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R6: one-hot while valid, idle otherwise
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(route) == 1);
  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> route == 3'b000);
  // R7: no hazard flags unless routed to the custom datapath
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !route[0] |-> out_use == 6'b0);
  // R5: custom wins a conflicted region
  a_r5_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_custom && sel_cop && in_kind != K_RSV) |=> route == RT_CUS);
  // R9: reserved class in a custom region faults
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_custom && in_kind == K_RSV) |=> route == RT_FLT);
endmodule

// File: tb/ext_op_router_bench.sv
module ext_op_router_bench;
  localparam logic [7:0] C_CUS = 8'h87;
  localparam logic [7:0] C_PRS = 8'hF0;
  localparam logic [7:0] C_ENA = 8'hB0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg_custom = C_CUS, cfg_cp_present = C_PRS, cfg_cp_enable = C_ENA;
  logic in_valid = 1'b0;
  logic [2:0] in_region = '0;
  logic in_bank = 1'b0;
  logic [1:0] in_kind = '0;
  logic in_acc = 1'b0, in_dual = 1'b0;
  logic [12:0] in_imm = '0;
  logic out_valid, out_bank, cfg_err;
  logic [2:0] route, out_opc;
  logic [1:0] out_kind;
  logic [9:0] out_const;
  logic [5:0] out_use;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_op_router u_ext_op_router (
    .clk(clk), .rst_n(rst_n), .cfg_custom(cfg_custom), .cfg_cp_present(cfg_cp_present),
    .cfg_cp_enable(cfg_cp_enable), .in_valid(in_valid), .in_region(in_region),
    .in_bank(in_bank), .in_kind(in_kind), .in_acc(in_acc), .in_dual(in_dual),
    .in_imm(in_imm), .out_valid(out_valid), .route(route), .out_bank(out_bank),
    .out_kind(out_kind), .out_opc(out_opc), .out_const(out_const), .out_use(out_use),
    .cfg_err(cfg_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_route(input int r, input int k);
    if (C_CUS[r]) return (k == 3) ? 3'b100 : 3'b001;
    if (C_PRS[r] && C_ENA[r]) return 3'b010;
    return 3'b100;
  endfunction

  function automatic logic [5:0] exp_use(input logic [2:0] rt, input int b, input int k,
                                         input int a, input int d);
    if (rt != 3'b001) return 6'b0;
    return {(d == 1 && b == 0), (b == 0), 1'b1, (a == 1), (k == 2), (k != 0)};
  endfunction

  function automatic logic [9:0] exp_const(input int k, input logic [12:0] imm);
    int w;
    w = (k == 0) ? 13 : (k == 1) ? 9 : 6;
    return 10'((imm >> 3) & ((13'd1 << (w - 3)) - 1));
  endfunction

  task automatic issue(input int r, input int b, input int k, input int a, input int d,
                       input logic [12:0] imm);
    @(negedge clk);
    in_valid = 1'b1; in_region = 3'(r); in_bank = b[0]; in_kind = 2'(k);
    in_acc = a[0]; in_dual = d[0]; in_imm = imm;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_all(input string req, input int r, input int b, input int k,
                            input int a, input int d, input logic [12:0] imm);
    logic [2:0] er;
    er = exp_route(r, k);
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " route"}, 32'(route), 32'(er));
    check({req, " R7 use"}, 32'(out_use), 32'(exp_use(er, b, k, a, d)));
    check({req, " R10 bank/kind"}, 32'({out_bank, out_kind}), 32'({b[0], 2'(k)}));
    check({req, " R8 opc"}, 32'(out_opc), 32'(imm[2:0]));
    check({req, " R8 const"}, 32'(out_const), 32'(exp_const(k, imm)));
  endtask

  task automatic run_one(input string req, input int r, input int b, input int k,
                         input int a, input int d, input logic [12:0] imm);
    issue(r, b, k, a, d, imm);
    expect_all(req, r, b, k, a, d, imm);
  endtask

  task automatic t_reset;
    check("R6 reset valid", 32'(out_valid), 32'd0);
    check("R6 reset route", 32'(route), 32'd0);
  endtask

  task automatic t_regions;
    run_one("R2 custom r0", 0, 0, 1, 1, 1, 13'h1ABC);
    run_one("R3 cop r4", 4, 0, 2, 0, 0, 13'h0F0F);
    run_one("R3 cop r5 kind3", 5, 1, 3, 1, 0, 13'h1234);
    run_one("R4 fault r6 disabled", 6, 0, 0, 0, 0, 13'h0555);
    run_one("R4 fault r3 absent", 3, 0, 1, 0, 0, 13'h0AAA);
    run_one("R5 conflict r7", 7, 0, 2, 1, 1, 13'h1FFF);
    check("R5 cfg_err", 32'(cfg_err), 32'd1);
    run_one("R9 reserved r1", 1, 0, 3, 0, 0, 13'h0777);
  endtask

  task automatic t_fp_and_imm;
    run_one("R7 fp r2", 2, 1, 2, 0, 1, 13'h0123);
    run_one("R8 k0 ones", 0, 0, 0, 0, 0, 13'h1FFF);
    run_one("R8 k1 ones", 1, 1, 1, 1, 0, 13'h1FFF);
    run_one("R8 k2 ones", 2, 0, 2, 0, 0, 13'h1FFF);
    run_one("R8 k2 high bits", 2, 0, 2, 0, 0, 13'h1FC5);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_valid = 1'b1; in_region = 3'd0; in_bank = 1'b0; in_kind = 2'd0;
    in_acc = 1'b0; in_dual = 1'b0; in_imm = 13'h0010;
    @(negedge clk);
    expect_all("R6 b2b first", 0, 0, 0, 0, 0, 13'h0010);
    in_region = 3'd4; in_kind = 2'd1; in_imm = 13'h0021;
    @(negedge clk);
    in_valid = 1'b0;
    expect_all("R6 b2b second", 4, 0, 1, 0, 0, 13'h0021);
    @(negedge clk);
    check("R6 drop valid", 32'(out_valid), 32'd0);
    check("R6 drop route", 32'(route), 32'd0);
  endtask

  task automatic t_cfg_hold;
    cfg_custom = 8'h00; cfg_cp_present = 8'h00; cfg_cp_enable = 8'h00;
    repeat (3) @(negedge clk);
    run_one("R1 hold r0", 0, 0, 1, 0, 0, 13'h0042);
    run_one("R1 hold r4", 4, 0, 1, 0, 0, 13'h0042);
    check("R1 hold cfg_err", 32'(cfg_err), 32'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_regions;
    t_fp_and_imm;
    t_back_to_back;
    t_cfg_hold;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule